// File: doc/BRIEF.md
# Bit-Sliced 384-Bit Permutation Engine

This block runs an iterated permutation over a 384-bit state, which is held as four rows of 96 bits. Row r sits in bits `[96r+95 : 96r]` of the state vectors. Each round has three steps, in this order:

1. A 7-bit round constant is XORed into the bottom bits of row 0.
2. A 4-input, 4-output S-box is applied to every one of the 96 bit columns. Column j takes bit j of rows 0 to 3 as its inputs.
3. Rows 1, 2 and 3 are rotated left by fixed distances. Row 0 is not rotated.

The block completes one round per clock. It is meant to sit under the mode logic of a lightweight authenticated-encryption or hash engine. That logic places a full state on `state_in`, gives the number of rounds on `rounds` and pulses `start`. It then reads `state_out` when `done` pulses.

A three-state controller sequences the work:
- **IDLE**: waiting. `start` moves it to **RUN**, or to **DONE** when `rounds` is zero.
- **RUN**: one round is applied on every clock. When the round counter reaches its last round, the controller moves to **DONE**.
- **DONE**: a single-cycle state that always returns to **IDLE**.

The round constants come from an internal 7-bit LFSR. The LFSR is reseeded on every accepted start and advances once per round.

Top module: `perm384_core`

## Requirements
- R1: While reset is high at a clock edge (synchronous, active high), the controller returns to IDLE. From the next cycle `busy` and `done` are 0 and `state_out` is all zeros.
- R2: A `start` sampled in IDLE captures `state_in` and `rounds`. For a count N > 0, `busy` is high for exactly N consecutive cycles, beginning with the cycle after the edge that sampled `start`.
- R3: `done` is high for exactly one cycle. That cycle begins N edges after the edge that sampled `start`, and `busy` is low during it.
- R4: A round count of 0 gives `done` in the cycle right after the start edge, with `state_out` equal to the captured `state_in`.
- R5: Each column nibble {row3,row2,row1,row0} = {a3,a2,a1,a0} is mapped by this sequence of steps: a0=~a0; t=a1; a1=(a1&a0)^a2; a2=a2|t; a0^=a3; a2^=a0; t^=a3; a0=(a0&a1)^t; a3^=a1; a1^=t&a2. The mapping is a bijection on 4 bits.
- R6: The round constant sequence starts at 0x01 on each accepted start. Each round it updates as c = {c[5:0], c[6]^c[5]}, so it runs 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x41, 0x03, 0x06, and so on. It has period 127 and its last value before repeating is 0x40. The constant is XORed into bits 6:0 of row 0 before the S-box step.
- R7: After the S-box step, rows 0, 1, 2 and 3 are rotated left by 0, 1, 8 and 55 bit positions, each within its own 96 bits.
- R8: A `start` sampled while in RUN or DONE is ignored. The running result, its timing and the held output are unaffected.
- R9: In IDLE or DONE with `start` low, `state_out` holds its value at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a permutation; accepted in IDLE only |
| rounds | input | 8 | Number of rounds to apply |
| state_in | input | 384 | Initial state; row r in bits [96r+95:96r] |
| state_out | output | 384 | Current or final state |
| busy | output | 1 | High while rounds are being applied |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The S-box is exercised with a state whose column j carries nibble j mod 16. A single round therefore shows all sixteen entries at once. Separate states are used for the round constant and the rotations:
- An all-zero state isolates the effect of the round constant.
- An all-ones state isolates the inversion and OR terms of the S-box.
- A state with a single set bit per row, on the row edges, shows any wrong rotation distance or direction as a displaced bit.

Random states are run with 0, 1, 2, 12, 130 and 255 rounds:
- The 130-round run detects a wrong LFSR period or tap.
- Back-to-back starts detect a constant that is not reseeded.
- Starts injected while the block is running or finishing detect a controller that accepts a command it should ignore.

// File: rtl/perm_pkg.sv
package perm_pkg;
    localparam int ROWS    = 4;
    localparam int ROW_W   = 96;
    localparam int STATE_W = ROWS * ROW_W;
    localparam int RC_W    = 7;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } phase_t;

    // Left-rotation distance of each row after the S-box step.
    function automatic int row_shift(input int r);
        case (r)
            1:       return 1;
            2:       return 8;
            3:       return 55;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/perm_sbox_slice.sv
module perm_sbox_slice #(
    parameter int W = 96
) (
    input  logic [W-1:0] in0,
    input  logic [W-1:0] in1,
    input  logic [W-1:0] in2,
    input  logic [W-1:0] in3,
    output logic [W-1:0] out0,
    output logic [W-1:0] out1,
    output logic [W-1:0] out2,
    output logic [W-1:0] out3
);
    // Word-wide bitwise steps: every bit column is an independent S-box.
    always_comb begin
        logic [W-1:0] a0, a1, a2, a3, t;
        a0 = ~in0;
        a1 = in1;
        a2 = in2;
        a3 = in3;
        t  = a1;
        a1 = (a1 & a0) ^ a2;
        a2 = a2 | t;
        a0 = a0 ^ a3;
        a2 = a2 ^ a0;
        t  = t ^ a3;
        a0 = (a0 & a1) ^ t;
        a3 = a3 ^ a1;
        t  = t & a2;
        a1 = a1 ^ t;
        out0 = a0;
        out1 = a1;
        out2 = a2;
        out3 = a3;
    end
endmodule

// File: rtl/perm_rc_lfsr.sv
module perm_rc_lfsr #(
    parameter int                RC_W = 7,
    parameter logic [RC_W-1:0]   SEED = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    output logic [RC_W-1:0] rc
);
    localparam int TAP_HI = RC_W - 1;
    localparam int TAP_LO = RC_W - 2;

    logic [RC_W-1:0] rc_q;

    always_ff @(posedge clk) begin
        if (rst)       rc_q <= '0;
        else if (load) rc_q <= SEED;
        else if (step) rc_q <= {rc_q[RC_W-2:0], rc_q[TAP_HI] ^ rc_q[TAP_LO]};
    end

    assign rc = rc_q;

    // R6: every accepted start reseeds the constant sequence
    a_r6_seed_on_load: assert property (@(posedge clk) disable iff (rst)
        load |=> rc == SEED);
    // R6: a stepping LFSR never falls into the all-zero lock-up state
    a_r6_no_lockup: assert property (@(posedge clk) disable iff (rst)
        (step && rc != '0) |=> rc != '0);
endmodule

// File: rtl/perm_round.sv
module perm_round
    import perm_pkg::*;
#(
    parameter int W    = ROW_W,
    parameter int CW   = RC_W
) (
    input  logic [ROWS*W-1:0] cur,
    input  logic [CW-1:0]     rc,
    output logic [ROWS*W-1:0] nxt
);
    logic [W-1:0] row0_k;
    logic [W-1:0] sb [ROWS];

    assign row0_k = cur[0 +: W] ^ {{(W-CW){1'b0}}, rc};

    perm_sbox_slice #(.W(W)) u_sbox (
        .in0  (row0_k),
        .in1  (cur[1*W +: W]),
        .in2  (cur[2*W +: W]),
        .in3  (cur[3*W +: W]),
        .out0 (sb[0]),
        .out1 (sb[1]),
        .out2 (sb[2]),
        .out3 (sb[3])
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_rot
        localparam int AMT = row_shift(r);
        if (AMT == 0) begin : g_pass
            assign nxt[r*W +: W] = sb[r];
        end else begin : g_turn
            assign nxt[r*W +: W] = {sb[r][W-AMT-1:0], sb[r][W-1:W-AMT]};
        end
    end
endmodule

// File: rtl/perm384_core.sv
module perm384_core
    import perm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [CNT_W-1:0]   rounds,
    input  logic [STATE_W-1:0] state_in,
    output logic [STATE_W-1:0] state_out,
    output logic               busy,
    output logic               done
);
    phase_t             phase_q, phase_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [STATE_W-1:0] st_q, st_step;
    logic [RC_W-1:0]    rc;
    logic               accept, running;

    assign accept  = (phase_q == S_IDLE) && start;
    assign running = (phase_q == S_RUN);

    // Next-phase logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            S_IDLE: if (start) phase_d = (rounds == '0) ? S_DONE : S_RUN;
            S_RUN:  if (cnt_q == CNT_W'(1)) phase_d = S_DONE;
            S_DONE: phase_d = S_IDLE;
            default: phase_d = S_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (rst) phase_q <= S_IDLE;
        else     phase_q <= phase_d;
    end

    // Outputs decoded from phase
    always_comb begin
        busy = (phase_q == S_RUN);
        done = (phase_q == S_DONE);
    end

    // State and round counter
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            st_q  <= state_in;
            cnt_q <= rounds;
        end else if (running) begin
            st_q  <= st_step;
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    perm_rc_lfsr #(.RC_W(RC_W), .SEED(RC_W'(1))) u_rc (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .step (running),
        .rc   (rc)
    );

    perm_round #(.W(ROW_W), .CW(RC_W)) u_round (
        .cur (st_q),
        .rc  (rc),
        .nxt (st_step)
    );

    assign state_out = st_q;

    // R1: reset leaves the controller idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done));
    // R2: while running there is always a round left
    a_r2_count_live: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt_q != '0);
    // R3: done is a single-cycle pulse and never overlaps busy
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r3_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));
    // R4: zero rounds finish at once with the input passed through
    a_r4_zero_pass: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && start && rounds == '0) |=> (done && state_out == $past(state_in)));
    // R6: no round is run with a zero constant
    a_r6_rc_live: assert property (@(posedge clk) disable iff (rst)
        busy |-> rc != '0);
    // R8: a start seen while running does not stop the run early
    a_r8_run_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start && cnt_q > CNT_W'(1)) |=> busy);
    // R9: the result holds when nothing is started
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(state_out));
endmodule

// File: tb/perm384_core_test.sv
module perm384_core_test;
    localparam int W  = 96;
    localparam int SW = 384;

    typedef struct {
        logic [SW-1:0] exp;
        int            at_edge;
        int            n;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [7:0]    rounds = '0;
    logic [SW-1:0] state_in = '0;
    logic [SW-1:0] state_out;
    logic          busy, done;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    busy_run = 0;
    logic  prev_done = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;  // 125 MHz

    perm384_core uut (
        .clk(clk), .rst(rst), .start(start), .rounds(rounds),
        .state_in(state_in), .state_out(state_out), .busy(busy), .done(done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [SW-1:0] act, input logic [SW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural model
    function automatic logic [3:0] sbox_nib(input logic [3:0] x);
        logic a0, a1, a2, a3, t;
        a0 = ~x[0]; a1 = x[1]; a2 = x[2]; a3 = x[3];
        t = a1;
        a1 = (a1 & a0) ^ a2;
        a2 = a2 | t;
        a0 = a0 ^ a3;
        a2 = a2 ^ a0;
        t = t ^ a3;
        a0 = (a0 & a1) ^ t;
        a3 = a3 ^ a1;
        a1 = a1 ^ (t & a2);
        return {a3, a2, a1, a0};
    endfunction

    function automatic logic [6:0] lfsr_next(input logic [6:0] c);
        return {c[5:0], c[6] ^ c[5]};
    endfunction

    function automatic logic [SW-1:0] model_round(input logic [SW-1:0] s, input logic [6:0] c);
        logic [SW-1:0] m, o;
        int sh[4];
        sh[0] = 0; sh[1] = 1; sh[2] = 8; sh[3] = 55;
        m = s;
        for (int b = 0; b < 7; b++) m[b] = m[b] ^ c[b];
        for (int j = 0; j < W; j++) begin
            logic [3:0] v;
            v = sbox_nib({m[3*W+j], m[2*W+j], m[W+j], m[j]});
            for (int r = 0; r < 4; r++) m[r*W+j] = v[r];
        end
        for (int r = 0; r < 4; r++)
            for (int j = 0; j < W; j++)
                o[r*W + ((j + sh[r]) % W)] = m[r*W + j];
        return o;
    endfunction

    function automatic logic [SW-1:0] model_perm(input logic [SW-1:0] s, input int n);
        logic [6:0] c;
        c = 7'h01;
        for (int k = 0; k < n; k++) begin
            s = model_round(s, c);
            c = lfsr_next(c);
        end
        return s;
    endfunction

    function automatic logic [SW-1:0] rand_state();
        logic [SW-1:0] v;
        for (int k = 0; k < SW/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // Driver: start one permutation, push its expectation, optionally
    // inject an ignored start at a running cycle or in the DONE cycle.
    task automatic run_op(input logic [SW-1:0] s, input int n, input string tag,
                          input int poke_mid, input bit poke_done);
        item_t it;
        logic [SW-1:0] junk;
        int k;
        junk = ~s;
        @(negedge clk);
        state_in = s;
        rounds = 8'(n);
        start = 1'b1;
        it.exp = model_perm(s, n);
        it.at_edge = cyc + 1 + n;
        it.n = n;
        it.tag = tag;
        sb_q.push_back(it);
        k = 0;
        do begin
            @(negedge clk);
            k++;
            start = (poke_mid > 0 && k == poke_mid) ? 1'b1 : 1'b0;
            if (start) begin state_in = junk; rounds = 8'd3; end
        end while (!done);
        start = 1'b0;
        if (poke_done) begin
            state_in = junk;
            rounds = 8'd4;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(!busy && state_out == it.exp, "R8", "start in DONE ignored",
                  state_out, it.exp);
            repeat (3) @(negedge clk);
            check(state_out == it.exp, "R9", "result held while idle",
                  state_out, it.exp);
        end
        wait (sb_q.size() == 0);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_run++;
            if (done) begin
                check(!prev_done, "R3", "done longer than one cycle", {383'd0, prev_done}, '0);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected done", {383'd0, done}, '0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(state_out == it.exp, it.tag, "result", state_out, it.exp);
                    check(cyc == it.at_edge, "R3", "done timing",
                          SW'(cyc), SW'(it.at_edge));
                    check(busy_run == it.n && !busy, "R2", "busy length",
                          SW'(busy_run), SW'(it.n));
                end
                busy_run = 0;
            end
            prev_done = done;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [6:0] seq[128];
        logic [6:0] c;
        logic [6:0] head[9];
        logic [15:0] seen;
        logic [SW-1:0] s;

        // R6 / R5: model self-consistency against the listed values
        head = '{7'h01, 7'h02, 7'h04, 7'h08, 7'h10, 7'h20, 7'h41, 7'h03, 7'h06};
        c = 7'h01;
        for (int i = 0; i < 128; i++) begin seq[i] = c; c = lfsr_next(c); end
        for (int i = 0; i < 9; i++)
            check(seq[i] == head[i], "R6", "constant sequence head", SW'(seq[i]), SW'(head[i]));
        check(seq[126] == 7'h40, "R6", "last constant", SW'(seq[126]), SW'(7'h40));
        check(seq[127] == 7'h01, "R6", "period 127", SW'(seq[127]), SW'(7'h01));
        seen = '0;
        for (int x = 0; x < 16; x++) seen[sbox_nib(4'(x))] = 1'b1;
        check(seen == 16'hFFFF, "R5", "S-box bijective", SW'(seen), SW'(16'hFFFF));

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy, "R1", "busy after reset", SW'(busy), '0);
        check(!done, "R1", "done after reset", SW'(done), '0);
        check(state_out == '0, "R1", "state after reset", state_out, '0);

        // R6: zero state shows the constant path
        run_op('0, 1, "R6", 0, 1'b0);
        // R5: all ones
        run_op({SW{1'b1}}, 3, "R5", 0, 1'b0);
        // R5: full truth table, column j = j mod 16
        for (int j = 0; j < W; j++)
            for (int r = 0; r < 4; r++) s[r*W + j] = 1'((j % 16) >> r);
        run_op(s, 1, "R5", 0, 1'b0);
        // R7: single bits at the row edges
        s = '0;
        s[W-1] = 1'b1; s[W] = 1'b1; s[2*W+W-1] = 1'b1; s[3*W+40] = 1'b1;
        run_op(s, 1, "R7", 0, 1'b0);
        // R4: zero rounds
        s = rand_state();
        run_op(s, 0, "R4", 0, 1'b0);
        // R8: start injected mid-run
        run_op(rand_state(), 12, "R8", 4, 1'b0);
        // R6: wraps the constant period; R8/R9 in DONE
        run_op(rand_state(), 130, "R6", 0, 1'b1);
        // R6: reseed on back-to-back starts
        run_op(rand_state(), 2, "R6", 0, 1'b0);
        run_op(rand_state(), 1, "R6", 0, 1'b0);
        // R2: maximum count
        run_op(rand_state(), 255, "R2", 0, 1'b0);

        repeat (2) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule